// File: doc/BRIEF.md
# Double-data-rate read burst output sequencer

This block is the output side of a double-data-rate memory device model. It takes read, burst-stop and row-close commands, and for each read it produces the data elements and the data strobe on the right clock halves. The elements arrive a programmable number of cycles after the command. Every clock cycle is shown as two output slots, a rising-half slot and a falling-half slot, and a downstream serialiser puts these slots on the pins.

For each element, the block asks a storage model for the data through a combinational fetch port. It gives two column addresses per cycle and gets back two data words in the same cycle. The block builds the strobe preamble and postamble and runs back-to-back bursts as one unbroken stream. A later read, a burst stop or a row close cuts a running burst short, with the same latency as a read. When nothing is due, the block releases both the data and the strobe (output enables low).

Encodings used on the ports are as follows. The command is 0 for no operation, 1 for read, 2 for burst stop and 3 for row close. The latency select is 0 for 2 cycles, 1 for 2.5 cycles and 2 for 3 cycles. The burst select is 0 for 2 elements, 1 for 4 elements and 2 for 8 elements. Latency and burst select must stay stable while commands are in flight.

States of the controller:
- `ST_IDLE`: the bus is released.
- `ST_PREAMBLE`: the strobe is driven low and there is no data.
- `ST_BURST`: one element pair is driven per cycle.

Transitions of the controller:
- A read that has reached its latency goes to `ST_BURST` from any state.
- A stop or row close that has reached its latency goes to `ST_PREAMBLE` if a read is due one cycle later, and otherwise to `ST_IDLE`.
- `ST_BURST` stays in `ST_BURST` while pairs remain.
- From any other case, the controller goes to `ST_PREAMBLE` when a read is due next cycle, and otherwise to `ST_IDLE`.

Top module: `ddr_rd_seq`

## Requirements
- R1: With latency select 0 (2 cycles) or 2 (3 cycles), the first element of a read issued in cycle c is driven in the rising-half slot of cycle c+2 or c+3.
- R2: Two elements go out per cycle, rising half first. Element k of a burst starting at column s has column (s with its low log2(BL) bits cleared) OR ((s+k) mod BL), so the sequence wraps inside its aligned block. Its data is the fetch-port word for that column.
- R3: If the strobe is not already driven in the slot just before a burst's first element, the strobe is driven low, with no data, in the two slots just before that element (the preamble).
- R4: The strobe is high with even-numbered elements and low with odd-numbered ones, so the last element of a burst goes out with the strobe low (the postamble).
- R5: In every slot with no element or preamble, the data and strobe enables are 0 and the data and strobe values are 0. This is also the state out of reset.
- R6: A read issued exactly BL/2 cycles after the previous read continues the stream with no empty slot and no new preamble.
- R7: A read issued while a burst is running cuts that burst off. The new burst's first element takes the slot its own latency gives.
- R8: A burst stop issued in cycle c releases every slot from the one where a read issued in cycle c would start.
- R9: A row close is handled exactly like a burst stop: it ends the burst with read latency.
- R10: With latency select 1 (2.5 cycles), all data and strobe output moves one slot later than with 2 cycles, so the first element appears in the falling-half slot of cycle c+2.
- R11: Burst select 0, 1 and 2 give bursts of 2, 4 and 8 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_i | input | 2 | Command: 0 none, 1 read, 2 burst stop, 3 row close |
| col_i | input | COL_W | Start column of a read |
| cl_sel | input | 2 | Latency select: 0 = 2, 1 = 2.5, 2 = 3 cycles |
| bl_sel | input | 2 | Burst select: 0 = 2, 1 = 4, 2 = 8 elements |
| fetch_col_even | output | COL_W | Column of this cycle's first element |
| fetch_col_odd | output | COL_W | Column of this cycle's second element |
| fetch_even | input | DQ_W | Storage word for fetch_col_even |
| fetch_odd | input | DQ_W | Storage word for fetch_col_odd |
| dq_rise | output | DQ_W | Data in the rising-half slot |
| dq_fall | output | DQ_W | Data in the falling-half slot |
| dq_oe_rise | output | 1 | Data enable, rising half |
| dq_oe_fall | output | 1 | Data enable, falling half |
| dqs_rise | output | 1 | Strobe level, rising half |
| dqs_fall | output | 1 | Strobe level, falling half |
| dqs_oe_rise | output | 1 | Strobe enable, rising half |
| dqs_oe_fall | output | 1 | Strobe enable, falling half |

## Verification
A read issued in cycle c has its first element due at half-slot 2(c+2), 2(c+2)+1 or 2(c+3), depending on the latency select. Its preamble is due in the two half-slots before that. A stop releases the bus from the half-slot a read issued in the same cycle would use. The bench turns every scheduled command into an expected value for each half-slot before the run. It then drives each command half a clock before the edge that samples it, and it compares both half-slots of every cycle half a clock after the edge that updates them. Each comparison is therefore made at the exact slot where the requirements place the result.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_READ = 2'd1,
        CMD_BST  = 2'd2,
        CMD_PRE  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PREAMBLE = 2'd1,
        ST_BURST    = 2'd2
    } st_e;

    // Control bits of one half-cycle output slot.
    typedef struct packed {
        logic dq_oe;
        logic dqs_oe;
        logic dqs_lvl;
    } slot_ctl_t;

endpackage

// File: rtl/ddr_rd_cmd_pipe.sv
// Delays commands so that the controller sees each one a fixed number of
// cycles ahead of its first output slot (hi tap) and one cycle earlier (lo tap).
module ddr_rd_cmd_pipe #(
    parameter int COL_W = 10,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [1:0]       cl_int,
    output logic [1:0]       hi_cmd,
    output logic [COL_W-1:0] hi_col,
    output logic [1:0]       lo_cmd
);
    localparam int NREG = DEPTH - 1;

    logic [1:0]       cmd_r [NREG];
    logic [COL_W-1:0] col_r [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) begin
                cmd_r[k] <= 2'd0;
                col_r[k] <= '0;
            end
        end else begin
            cmd_r[0] <= cmd_i;
            col_r[0] <= col_i;
            for (int k = 1; k < NREG; k++) begin
                cmd_r[k] <= cmd_r[k-1];
                col_r[k] <= col_r[k-1];
            end
        end
    end

    // hi tap: delay cl_int-1 cycles; lo tap: delay cl_int-2 cycles.
    always_comb begin
        hi_cmd = 2'd0;
        hi_col = '0;
        lo_cmd = cmd_i;
        for (int k = 0; k < NREG; k++) begin
            if (k == int'(cl_int) - 2) begin
                hi_cmd = cmd_r[k];
                hi_col = col_r[k];
            end
            if (k == int'(cl_int) - 3) begin
                lo_cmd = cmd_r[k];
            end
        end
    end
endmodule

// File: rtl/ddr_rd_burst_fsm.sv
// Burst controller: one element pair per cycle, preamble, truncation.
module ddr_rd_burst_fsm
    import ddr_rd_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int DQ_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       hi_cmd,
    input  logic [COL_W-1:0] hi_col,
    input  logic [1:0]       lo_cmd,
    input  logic [1:0]       bl_sel,
    input  logic [DQ_W-1:0]  fetch_even,
    input  logic [DQ_W-1:0]  fetch_odd,
    output logic [COL_W-1:0] col_even,
    output logic [COL_W-1:0] col_odd,
    output slot_ctl_t        ctl_rise,
    output slot_ctl_t        ctl_fall,
    output logic [DQ_W-1:0]  dat_rise,
    output logic [DQ_W-1:0]  dat_fall
);
    localparam int OW = 3;
    localparam int HW = COL_W - OW;

    st_e              st, st_n, wait_st;
    logic [COL_W-1:0] base, base_n;
    logic [OW-1:0]    offs, offs_n, left, left_n;
    logic [OW-1:0]    mask, npairs;

    always_comb begin
        unique case (bl_sel)
            2'd0:    begin mask = 3'd1; npairs = 3'd1; end
            2'd1:    begin mask = 3'd3; npairs = 3'd2; end
            default: begin mask = 3'd7; npairs = 3'd4; end
        endcase
    end

    // Where the controller rests when no pair is due next cycle.
    assign wait_st = (lo_cmd == CMD_READ) ? ST_PREAMBLE : ST_IDLE;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            base <= '0;
            offs <= '0;
            left <= '0;
        end else begin
            st   <= st_n;
            base <= base_n;
            offs <= offs_n;
            left <= left_n;
        end
    end

    // Next-state logic.
    always_comb begin
        st_n   = ST_IDLE;
        base_n = base;
        offs_n = offs;
        left_n = left;
        if (hi_cmd == CMD_READ) begin
            st_n   = ST_BURST;
            base_n = hi_col & ~{{HW{1'b0}}, mask};
            offs_n = hi_col[OW-1:0] & mask;
            left_n = npairs - 3'd1;
        end else if (hi_cmd == CMD_BST || hi_cmd == CMD_PRE) begin
            st_n = wait_st;
        end else begin
            unique case (st)
                ST_BURST: begin
                    if (left != '0) begin
                        st_n   = ST_BURST;
                        offs_n = (offs + 3'd2) & mask;
                        left_n = left - 3'd1;
                    end else begin
                        st_n = wait_st;
                    end
                end
                ST_IDLE, ST_PREAMBLE: st_n = wait_st;
                default:              st_n = ST_IDLE;
            endcase
        end
    end

    assign col_even = base | {{HW{1'b0}}, offs};
    assign col_odd  = base | {{HW{1'b0}}, (offs + 3'd1) & mask};

    // Output logic.
    always_comb begin
        ctl_rise = '0;
        ctl_fall = '0;
        dat_rise = '0;
        dat_fall = '0;
        unique case (st)
            ST_BURST: begin
                ctl_rise = '{dq_oe: 1'b1, dqs_oe: 1'b1, dqs_lvl: 1'b1};
                ctl_fall = '{dq_oe: 1'b1, dqs_oe: 1'b1, dqs_lvl: 1'b0};
                dat_rise = fetch_even;
                dat_fall = fetch_odd;
            end
            ST_PREAMBLE: begin
                ctl_rise = '{dq_oe: 1'b0, dqs_oe: 1'b1, dqs_lvl: 1'b0};
                ctl_fall = '{dq_oe: 1'b0, dqs_oe: 1'b1, dqs_lvl: 1'b0};
            end
            ST_IDLE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr_rd_half_shift.sv
// Optional one-slot delay for the half-cycle latency setting.
module ddr_rd_half_shift
    import ddr_rd_pkg::*;
#(
    parameter int DQ_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            half_en,
    input  slot_ctl_t       in_ctl_rise,
    input  slot_ctl_t       in_ctl_fall,
    input  logic [DQ_W-1:0] in_dat_rise,
    input  logic [DQ_W-1:0] in_dat_fall,
    output slot_ctl_t       out_ctl_rise,
    output slot_ctl_t       out_ctl_fall,
    output logic [DQ_W-1:0] out_dat_rise,
    output logic [DQ_W-1:0] out_dat_fall
);
    slot_ctl_t       held_ctl;
    logic [DQ_W-1:0] held_dat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_ctl <= '0;
            held_dat <= '0;
        end else begin
            held_ctl <= in_ctl_fall;
            held_dat <= in_dat_fall;
        end
    end

    always_comb begin
        if (half_en) begin
            out_ctl_rise = held_ctl;
            out_dat_rise = held_dat;
            out_ctl_fall = in_ctl_rise;
            out_dat_fall = in_dat_rise;
        end else begin
            out_ctl_rise = in_ctl_rise;
            out_dat_rise = in_dat_rise;
            out_ctl_fall = in_ctl_fall;
            out_dat_fall = in_dat_fall;
        end
    end
endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq
    import ddr_rd_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int DQ_W   = 8,
    parameter int MAX_CL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [1:0]       cl_sel,
    input  logic [1:0]       bl_sel,
    output logic [COL_W-1:0] fetch_col_even,
    output logic [COL_W-1:0] fetch_col_odd,
    input  logic [DQ_W-1:0]  fetch_even,
    input  logic [DQ_W-1:0]  fetch_odd,
    output logic [DQ_W-1:0]  dq_rise,
    output logic [DQ_W-1:0]  dq_fall,
    output logic             dq_oe_rise,
    output logic             dq_oe_fall,
    output logic             dqs_rise,
    output logic             dqs_fall,
    output logic             dqs_oe_rise,
    output logic             dqs_oe_fall
);
    logic [1:0]       cl_int;
    logic             half_en;
    logic [1:0]       hi_cmd, lo_cmd;
    logic [COL_W-1:0] hi_col;
    slot_ctl_t        c_rise, c_fall, o_rise, o_fall;
    logic [DQ_W-1:0]  d_rise, d_fall;

    assign cl_int  = (cl_sel == 2'd2) ? 2'd3 : 2'd2;
    assign half_en = (cl_sel == 2'd1);

    ddr_rd_cmd_pipe #(.COL_W(COL_W), .DEPTH(MAX_CL)) u_pipe (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .col_i(col_i),
        .cl_int(cl_int), .hi_cmd(hi_cmd), .hi_col(hi_col), .lo_cmd(lo_cmd)
    );

    ddr_rd_burst_fsm #(.COL_W(COL_W), .DQ_W(DQ_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .hi_col(hi_col),
        .lo_cmd(lo_cmd), .bl_sel(bl_sel), .fetch_even(fetch_even),
        .fetch_odd(fetch_odd), .col_even(fetch_col_even), .col_odd(fetch_col_odd),
        .ctl_rise(c_rise), .ctl_fall(c_fall), .dat_rise(d_rise), .dat_fall(d_fall)
    );

    ddr_rd_half_shift #(.DQ_W(DQ_W)) u_half (
        .clk(clk), .rst_n(rst_n), .half_en(half_en),
        .in_ctl_rise(c_rise), .in_ctl_fall(c_fall),
        .in_dat_rise(d_rise), .in_dat_fall(d_fall),
        .out_ctl_rise(o_rise), .out_ctl_fall(o_fall),
        .out_dat_rise(dq_rise), .out_dat_fall(dq_fall)
    );

    assign dq_oe_rise  = o_rise.dq_oe;
    assign dq_oe_fall  = o_fall.dq_oe;
    assign dqs_rise    = o_rise.dqs_lvl;
    assign dqs_fall    = o_fall.dqs_lvl;
    assign dqs_oe_rise = o_rise.dqs_oe;
    assign dqs_oe_fall = o_fall.dqs_oe;
endmodule

// File: rtl/ddr_rd_seq_chk.sv
module ddr_rd_seq_chk
    import ddr_rd_pkg::*;
#(
    parameter int DQ_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      cmd_i,
    input logic [DQ_W-1:0] dq_rise,
    input logic            dq_oe_rise,
    input logic            dq_oe_fall,
    input logic            dqs_rise,
    input logic            dqs_fall,
    input logic            dqs_oe_rise,
    input logic            dqs_oe_fall
);
    // Data only follows a read within the latency window, or continues a stream.
    assert_no_data_without_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_rise || dq_oe_fall) |->
            ($past(dq_oe_rise || dq_oe_fall) || $past(cmd_i == CMD_READ, 2)
             || $past(cmd_i == CMD_READ, 3)));

    // The slot before any data slot has the strobe driven (preamble or data).
    assert_strobe_before_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_rise |-> $past(dqs_oe_fall));
    assert_strobe_before_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_fall |-> dqs_oe_rise);

    // Two data slots in one cycle carry opposite strobe levels.
    assert_strobe_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_rise && dq_oe_fall) |-> (dqs_rise != dqs_fall));

    // Released slots carry zeros.
    assert_idle_data_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe_rise |-> (dq_rise == '0));
    assert_idle_strobe_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dqs_oe_fall |-> !dqs_fall);
endmodule

bind ddr_rd_seq ddr_rd_seq_chk #(.DQ_W(DQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .dq_rise(dq_rise),
    .dq_oe_rise(dq_oe_rise), .dq_oe_fall(dq_oe_fall),
    .dqs_rise(dqs_rise), .dqs_fall(dqs_fall),
    .dqs_oe_rise(dqs_oe_rise), .dqs_oe_fall(dqs_oe_fall)
);

// File: tb/sim_ddr_rd_seq.sv
`timescale 1ns/1ps
module sim_ddr_rd_seq;
    localparam int NC = 40;
    localparam int NS = 2 * NC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd_i = 2'd0;
    logic [9:0] col_i = '0;
    logic [1:0] cl_sel = 2'd0;
    logic [1:0] bl_sel = 2'd0;
    logic [9:0] fetch_col_even, fetch_col_odd;
    logic [7:0] fetch_even, fetch_odd, dq_rise, dq_fall;
    logic       dq_oe_rise, dq_oe_fall, dqs_rise, dqs_fall, dqs_oe_rise, dqs_oe_fall;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_word(input logic [9:0] c);
        return 8'(c * 10'd13 + 10'd7);
    endfunction

    // Storage model behind the fetch port.
    assign fetch_even = mem_word(fetch_col_even);
    assign fetch_odd  = mem_word(fetch_col_odd);

    ddr_rd_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .col_i(col_i),
        .cl_sel(cl_sel), .bl_sel(bl_sel),
        .fetch_col_even(fetch_col_even), .fetch_col_odd(fetch_col_odd),
        .fetch_even(fetch_even), .fetch_odd(fetch_odd),
        .dq_rise(dq_rise), .dq_fall(dq_fall),
        .dq_oe_rise(dq_oe_rise), .dq_oe_fall(dq_oe_fall),
        .dqs_rise(dqs_rise), .dqs_fall(dqs_fall),
        .dqs_oe_rise(dqs_oe_rise), .dqs_oe_fall(dqs_oe_fall)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    int         sc_cmd [NC];
    int         sc_col [NC];
    bit         e_oe   [NS];
    bit         e_so   [NS];
    bit         e_lv   [NS];
    logic [7:0] e_d    [NS];
    string      e_tag  [NS];

    task automatic clear_sc();
        for (int c = 0; c < NC; c++) begin
            sc_cmd[c] = 0;
            sc_col[c] = 0;
        end
    endtask

    task automatic put(input int c, input int cmd, input int col);
        sc_cmd[c] = cmd;
        sc_col[c] = col;
    endtask

    task automatic wipe_from(input int h);
        for (int i = h; i < NS; i++) begin
            if (i >= 0) begin
                e_oe[i] = 0; e_so[i] = 0; e_lv[i] = 0; e_d[i] = '0; e_tag[i] = "R5";
            end
        end
    endtask

    // Behavioural slot schedule: 1 = read, 2 = stop, 3 = row close.
    task automatic build(input int cl, input int bl);
        int cli, hf, bln, h0;
        int starts[$];
        cli = (cl == 2) ? 3 : 2;
        hf  = (cl == 1) ? 1 : 0;
        bln = (bl == 0) ? 2 : (bl == 1) ? 4 : 8;
        wipe_from(0);
        for (int c = 0; c < NC; c++) begin
            h0 = 2 * (c + cli) + hf;
            if (sc_cmd[c] == 1) begin
                wipe_from(h0);
                starts.push_back(h0);
                for (int k = 0; k < bln; k++) begin
                    int colk;
                    colk = (sc_col[c] & ~(bln - 1)) | ((sc_col[c] + k) & (bln - 1));
                    if (h0 + k < NS) begin
                        e_oe[h0+k] = 1; e_so[h0+k] = 1; e_lv[h0+k] = (k % 2 == 0);
                        e_d[h0+k] = mem_word(10'(colk)); e_tag[h0+k] = "R2";
                    end
                end
            end else if (sc_cmd[c] == 2 || sc_cmd[c] == 3) begin
                wipe_from(h0);
            end
        end
        foreach (starts[i]) begin
            int s;
            s = starts[i];
            if (s >= 2 && s < NS && !e_so[s-1]) begin
                e_so[s-1] = 1; e_lv[s-1] = 0; e_tag[s-1] = "R3";
                e_so[s-2] = 1; e_lv[s-2] = 0; e_tag[s-2] = "R3";
            end
        end
    endtask

    task automatic check_slot(input int h, input bit oe, input logic [7:0] d,
                              input bit so, input bit lv, input string sc);
        n_cmp++;
        if (oe !== e_oe[h] || d !== e_d[h] || so !== e_so[h] || lv !== e_lv[h]) begin
            n_bad++;
            $display("FAIL %s [%s] slot %0d: got oe=%0b d=%h dqs_oe=%0b dqs=%0b exp oe=%0b d=%h dqs_oe=%0b dqs=%0b",
                     e_tag[h], sc, h, oe, d, so, lv, e_oe[h], e_d[h], e_so[h], e_lv[h]);
        end
    endtask

    task automatic run_case(input int cl, input int bl, input string sc);
        build(cl, bl);
        rst_n  = 1'b0;
        cmd_i  = 2'd0;
        col_i  = '0;
        cl_sel = 2'(cl);
        bl_sel = 2'(bl);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NC; c++) begin
            check_slot(2 * c, dq_oe_rise, dq_rise, dqs_oe_rise, dqs_rise, sc);
            check_slot(2 * c + 1, dq_oe_fall, dq_fall, dqs_oe_fall, dqs_fall, sc);
            cmd_i = 2'(sc_cmd[c]);
            col_i = 10'(sc_col[c]);
            @(negedge clk);
        end
    endtask

    initial begin
        // R1 R2 R4 R5 R9: latency 2, burst 4, wrapping start, later cut by row close.
        clear_sc(); put(1, 1, 5); put(8, 1, 0); put(9, 3, 0);
        run_case(0, 1, "R1 R2 R4 R5 R9 cl2 bl4");
        // R1 R6 R7: latency 3, burst 8, seamless chain then mid-burst read.
        clear_sc(); put(1, 1, 3); put(5, 1, 16); put(7, 1, 42); put(20, 1, 1);
        run_case(2, 2, "R1 R6 R7 cl3 bl8");
        // R10 R8 R3: latency 2.5, burst 4, chain then burst stop.
        clear_sc(); put(1, 1, 2); put(3, 1, 9); put(4, 2, 0); put(12, 1, 6);
        run_case(1, 1, "R10 R8 R3 cl2.5 bl4");
        // R9 R3: row close then read after a gap gets a fresh preamble.
        clear_sc(); put(2, 1, 0); put(4, 3, 0); put(5, 1, 12);
        run_case(0, 2, "R9 R3 cl2 bl8");
        // R11 R6: burst of 2, back-to-back reads, late stop without effect.
        clear_sc(); put(1, 1, 4); put(2, 1, 7); put(3, 1, 12); put(9, 1, 5); put(10, 2, 0);
        run_case(2, 0, "R11 R6 cl3 bl2");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL R5 watchdog: got run still active, exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule